// File: doc/BRIEF.md
# Flash Command Decoder with Block Protection

This block is the command front end of a 32-block NOR-style flash array. The host issues bus writes that carry an address and a data word. The decoder interprets them as one-cycle commands or two-cycle sequences. It decides whether bus reads return array contents, a status byte or the two signature bytes. When a program or erase sequence completes, it sends a start request to a separate program/erase engine. That engine is modelled as a start pulse followed later by a done pulse.

Every start request first passes a protection gate. A block is protected when its lock bit is set. A block is also protected when the pin that guards its range is low. The top-block pin guards only block 31, and the write-protect pin guards only blocks 0 to 30. A low programming-voltage flag refuses every program or erase. A refused request produces no start and leaves sticky error flags in the status byte. Only a clear command removes those flags. While the engine works, the decoder accepts only a status-read command and a suspend command.

Top module: `flash_cmd_decoder`

## Requirements
- R1: When reset is released, reads return `arr_rdata` (array mode), `eng_start` is low, and the status byte reads 80h once status mode is selected.
- R2: Command FFh selects array reads, 70h selects status reads and 90h selects signature reads. In signature mode, address 0 returns 20h and address 1 returns 2Eh.
- R3: A write of 40h or 10h followed by a second write pulses `eng_start` in the cycle after that second write. The pulse carries op 0 (program), the full address and the byte in bits 7:0 of the data. Later reads return status.
- R4: A write of 30h followed by a second write starts op 1 (four-byte program). It carries all 32 data bits and the address with bits 1:0 forced to zero.
- R5: A write of 20h followed by D0h starts op 2 (block erase). A write of 80h followed by 10h starts op 3 (chip erase). Any other confirm byte gives no start and sets status bits 5 and 4.
- R6: With `tbl_n` low, block 31 (address bits 20:16) is protected and blocks 0 to 30 are unaffected. With `wp_n` low, blocks 0 to 30 are protected and block 31 is unaffected.
- R7: A block whose lock bit is set is protected. A program or erase aimed at a protected block gives no start and sets status bit 1. It also sets bit 4 for a program or bit 5 for an erase.
- R8: A program or erase attempted with `vpp_ok` low gives no start. It sets status bit 3 together with bit 4 (program) or bit 5 (erase).
- R9: While the engine is busy, status bit 7 is 0 and every command other than 70h and B0h is ignored. `eng_done` sets bit 7 back to 1.
- R10: B0h while busy pulses `eng_suspend` and sets bit 7. It also sets bit 2 for a program or bit 6 for a block erase. D0h while suspended pulses `eng_resume` and clears that bit. B0h during a chip erase is ignored.
- R11: Command 50h clears status bits 1, 3, 4 and 5 and keeps the read mode already in force. These bits otherwise stay set.
- R12: Reset asserts `eng_abort` while it is low, cancels a busy operation and returns all lock bits to their default value of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | 21 | Bus write address |
| wr_data | input | 32 | Bus write data; commands use bits 7:0 |
| rd_addr | input | 21 | Bus read address |
| arr_rdata | input | 8 | Byte read from the array at rd_addr |
| rd_data | output | 8 | Read result chosen by the current read mode |
| lock_we | input | 1 | Lock bit write strobe |
| lock_blk | input | 5 | Block whose lock bit is written |
| lock_val | input | 1 | New lock bit value |
| wp_n | input | 1 | Low protects blocks 0 to 30 |
| tbl_n | input | 1 | Low protects block 31 |
| vpp_ok | input | 1 | Programming voltage is above lockout |
| eng_start | output | 1 | One-cycle start request to the engine |
| eng_op | output | 2 | Operation: 0 program, 1 four-byte, 2 block erase, 3 chip erase |
| eng_addr | output | 21 | Target address of the request |
| eng_data | output | 32 | Data of the request |
| eng_suspend | output | 1 | One-cycle suspend request |
| eng_resume | output | 1 | One-cycle resume request |
| eng_done | input | 1 | Engine completion pulse |
| eng_abort | output | 1 | Abort to the engine while reset is low |

## Verification
Most faults inside this decoder appear at `rd_data` on the read that follows a write. A wrong command state shows up as an unexpected read source or a missing ready bit. A dropped or misplaced sticky error flag shows up as a wrong status byte. A protection or voltage check that is wrong appears within one cycle of the confirming write, either as an `eng_start` pulse that should not occur or as a missing one. Busy-state leakage shows up as a read source that changes after a command that should have been ignored.

// File: rtl/fcd_pkg.sv
// Package: shared types and codes for the flash command decoder.
// Assumes 8-bit command bytes carried in the low byte of a bus write.
package fcd_pkg;

    typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_SIG} rd_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PROG, ST_QUAD, ST_ERASE, ST_CHIP, ST_BUSY, ST_SUSP
    } cmd_state_e;

    typedef enum logic [1:0] {OP_PROG, OP_QUAD, OP_BERASE, OP_CERASE} eng_op_e;

    localparam logic [7:0] CMD_READ    = 8'hFF;
    localparam logic [7:0] CMD_STATUS  = 8'h70;
    localparam logic [7:0] CMD_SIG     = 8'h90;
    localparam logic [7:0] CMD_CLEAR   = 8'h50;
    localparam logic [7:0] CMD_PROG_A  = 8'h40;
    localparam logic [7:0] CMD_PROG_B  = 8'h10;
    localparam logic [7:0] CMD_QUAD    = 8'h30;
    localparam logic [7:0] CMD_ERASE   = 8'h20;
    localparam logic [7:0] CMD_CHIP    = 8'h80;
    localparam logic [7:0] CMD_CHIP_OK = 8'h10;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;

    localparam int SB_READY = 7;
    localparam int SB_ESUSP = 6;
    localparam int SB_EERR  = 5;
    localparam int SB_PERR  = 4;
    localparam int SB_VPP   = 3;
    localparam int SB_PSUSP = 2;
    localparam int SB_PROT  = 1;

endpackage

// File: rtl/fcd_protect.sv
// Module: per-block lock bits plus pin overrides giving a protection vector.
// Assumes the top block is the highest-numbered block and that each pin
// guards only its own range.
module fcd_protect #(
    parameter int BLK_W = 5,
    parameter int NBLK  = 1 << BLK_W,
    parameter logic [NBLK-1:0] LOCK_RST = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_we,
    input  logic [BLK_W-1:0] lock_blk,
    input  logic             lock_val,
    input  logic             wp_n,
    input  logic             tbl_n,
    output logic [NBLK-1:0]  prot_vec
);

    logic [NBLK-1:0] lock_q;

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        // Hold one lock bit, back to its default on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lock_q[b] <= LOCK_RST[b];
            else if (lock_we && (lock_blk == BLK_W'(b)))
                lock_q[b] <= lock_val;
        end

        if (b == NBLK - 1) begin : g_top
            assign prot_vec[b] = lock_q[b] | ~tbl_n;
        end else begin : g_main
            assign prot_vec[b] = lock_q[b] | ~wp_n;
        end
    end

endmodule

// File: rtl/fcd_status.sv
// Module: status byte with sticky error flags and suspend flags.
// Assumes set and clear requests come from the command FSM as one-cycle pulses.
module fcd_status
    import fcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy,
    input  logic       set_prot,
    input  logic       set_vpp,
    input  logic       set_perr,
    input  logic       set_eerr,
    input  logic       clr_err,
    input  logic       set_esusp,
    input  logic       set_psusp,
    input  logic       clr_susp,
    output logic [7:0] status
);

    logic prot_q, vpp_q, perr_q, eerr_q, esusp_q, psusp_q;

    // Sticky error flags: set by refusals, cleared only by the clear command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q <= 1'b0;
            vpp_q  <= 1'b0;
            perr_q <= 1'b0;
            eerr_q <= 1'b0;
        end else if (clr_err) begin
            prot_q <= 1'b0;
            vpp_q  <= 1'b0;
            perr_q <= 1'b0;
            eerr_q <= 1'b0;
        end else begin
            prot_q <= prot_q | set_prot;
            vpp_q  <= vpp_q  | set_vpp;
            perr_q <= perr_q | set_perr;
            eerr_q <= eerr_q | set_eerr;
        end
    end

    // Suspend flags: set on suspend, cleared on resume.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_susp) begin
            esusp_q <= 1'b0;
            psusp_q <= 1'b0;
        end else begin
            esusp_q <= esusp_q | set_esusp;
            psusp_q <= psusp_q | set_psusp;
        end
    end

    // Assemble the status byte.
    always_comb begin
        status           = '0;
        status[SB_READY] = ~busy;
        status[SB_ESUSP] = esusp_q;
        status[SB_EERR]  = eerr_q;
        status[SB_PERR]  = perr_q;
        status[SB_VPP]   = vpp_q;
        status[SB_PSUSP] = psusp_q;
        status[SB_PROT]  = prot_q;
    end

endmodule

// File: rtl/fcd_rdmux.sv
// Module: chooses the read result from array, status or signature.
// Assumes signature bytes live only at addresses 0 and 1; elsewhere it reads 00h.
module fcd_rdmux
    import fcd_pkg::*;
#(
    parameter int         ADDR_W   = 21,
    parameter logic [7:0] MFR_CODE = 8'h20,
    parameter logic [7:0] DEV_CODE = 8'h2E
) (
    input  rd_mode_e          mode,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        arr_rdata,
    input  logic [7:0]        status,
    output logic [7:0]        rd_data
);

    // Pick the source for the current read mode.
    always_comb begin
        unique case (mode)
            RM_STATUS: rd_data = status;
            RM_SIG: begin
                if (rd_addr[ADDR_W-1:1] != '0) rd_data = 8'h00;
                else rd_data = rd_addr[0] ? DEV_CODE : MFR_CODE;
            end
            default:   rd_data = arr_rdata;
        endcase
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
// Module: command FSM of a block-structured flash. It decodes bus writes,
// gates engine starts through protection and voltage checks, and steers reads.
// Assumes the engine reports completion with a one-cycle eng_done pulse.
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int BLK_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        arr_rdata,
    output logic [7:0]        rd_data,
    input  logic              lock_we,
    input  logic [BLK_W-1:0]  lock_blk,
    input  logic              lock_val,
    input  logic              wp_n,
    input  logic              tbl_n,
    input  logic              vpp_ok,
    output logic              eng_start,
    output logic [1:0]        eng_op,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [DATA_W-1:0] eng_data,
    output logic              eng_suspend,
    output logic              eng_resume,
    input  logic              eng_done,
    output logic              eng_abort
);

    localparam int NBLK = 1 << BLK_W;

    cmd_state_e state_q, state_d;
    rd_mode_e   mode_q, mode_d;
    eng_op_e    op_q, op_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [DATA_W-1:0] data_q, data_d;
    logic start_q, start_d, susp_q, susp_d, res_q, res_d;
    logic set_prot, set_vpp, set_perr, set_eerr, clr_err;
    logic set_esusp, set_psusp, clr_susp;
    logic [NBLK-1:0] prot_vec;
    logic [7:0] status_w;
    logic [7:0] cmd;
    logic [BLK_W-1:0] blk;
    logic is_prog;

    assign cmd = wr_data[7:0];
    assign blk = wr_addr[ADDR_W-1 -: BLK_W];
    assign is_prog = (state_q == ST_PROG) || (state_q == ST_QUAD);

    fcd_protect #(.BLK_W(BLK_W)) u_prot (
        .clk(clk), .rst_n(rst_n), .lock_we(lock_we), .lock_blk(lock_blk),
        .lock_val(lock_val), .wp_n(wp_n), .tbl_n(tbl_n), .prot_vec(prot_vec)
    );

    fcd_status u_stat (
        .clk(clk), .rst_n(rst_n), .busy(state_q == ST_BUSY),
        .set_prot(set_prot), .set_vpp(set_vpp), .set_perr(set_perr),
        .set_eerr(set_eerr), .clr_err(clr_err), .set_esusp(set_esusp),
        .set_psusp(set_psusp), .clr_susp(clr_susp), .status(status_w)
    );

    fcd_rdmux #(.ADDR_W(ADDR_W)) u_rd (
        .mode(mode_q), .rd_addr(rd_addr), .arr_rdata(arr_rdata),
        .status(status_w), .rd_data(rd_data)
    );

    // Next-state decode of bus writes, engine events and protection checks.
    always_comb begin
        state_d = state_q;  mode_d = mode_q;  op_d = op_q;
        addr_d  = addr_q;   data_d = data_q;
        start_d = 1'b0;     susp_d = 1'b0;    res_d = 1'b0;
        set_prot = 1'b0; set_vpp = 1'b0; set_perr = 1'b0; set_eerr = 1'b0;
        clr_err = 1'b0; set_esusp = 1'b0; set_psusp = 1'b0; clr_susp = 1'b0;
        unique case (state_q)
            ST_IDLE: if (wr_en) begin
                unique case (cmd)
                    CMD_READ:   mode_d  = RM_ARRAY;
                    CMD_STATUS: mode_d  = RM_STATUS;
                    CMD_SIG:    mode_d  = RM_SIG;
                    CMD_CLEAR:  clr_err = 1'b1;
                    CMD_PROG_A, CMD_PROG_B: state_d = ST_PROG;
                    CMD_QUAD:   state_d = ST_QUAD;
                    CMD_ERASE:  state_d = ST_ERASE;
                    CMD_CHIP:   state_d = ST_CHIP;
                    default: ;
                endcase
            end
            ST_PROG, ST_QUAD, ST_ERASE, ST_CHIP: if (wr_en) begin
                mode_d  = RM_STATUS;
                state_d = ST_IDLE;
                if ((state_q == ST_ERASE && cmd != CMD_CONFIRM) ||
                    (state_q == ST_CHIP && cmd != CMD_CHIP_OK)) begin
                    set_perr = 1'b1;
                    set_eerr = 1'b1;
                end else if (!vpp_ok) begin
                    set_vpp  = 1'b1;
                    set_perr = is_prog;
                    set_eerr = !is_prog;
                end else if ((state_q == ST_CHIP) ? (|prot_vec) : prot_vec[blk]) begin
                    set_prot = 1'b1;
                    set_perr = is_prog;
                    set_eerr = !is_prog;
                end else begin
                    start_d = 1'b1;
                    state_d = ST_BUSY;
                    addr_d  = wr_addr;
                    data_d  = wr_data;
                    unique case (state_q)
                        ST_PROG: begin op_d = OP_PROG; data_d = DATA_W'(cmd); end
                        ST_QUAD: begin op_d = OP_QUAD; addr_d[1:0] = 2'b00; end
                        ST_ERASE: op_d = OP_BERASE;
                        default:  op_d = OP_CERASE;
                    endcase
                end
            end
            ST_BUSY: begin
                if (wr_en && cmd == CMD_STATUS) mode_d = RM_STATUS;
                if (eng_done) state_d = ST_IDLE;
                else if (wr_en && cmd == CMD_SUSPEND && op_q != OP_CERASE) begin
                    susp_d    = 1'b1;
                    state_d   = ST_SUSP;
                    set_esusp = (op_q == OP_BERASE);
                    set_psusp = (op_q != OP_BERASE);
                end
            end
            default: if (wr_en) begin
                unique case (cmd)
                    CMD_READ:   mode_d = RM_ARRAY;
                    CMD_STATUS: mode_d = RM_STATUS;
                    CMD_SIG:    mode_d = RM_SIG;
                    CMD_CONFIRM: begin
                        res_d    = 1'b1;
                        clr_susp = 1'b1;
                        state_d  = ST_BUSY;
                        mode_d   = RM_STATUS;
                    end
                    default: ;
                endcase
            end
        endcase
    end

    // Register FSM state, read mode and engine request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;  mode_q <= RM_ARRAY;  op_q <= OP_PROG;
            addr_q  <= '0;       data_q <= '0;
            start_q <= 1'b0;     susp_q <= 1'b0;      res_q <= 1'b0;
        end else begin
            state_q <= state_d;  mode_q <= mode_d;    op_q <= op_d;
            addr_q  <= addr_d;   data_q <= data_d;
            start_q <= start_d;  susp_q <= susp_d;    res_q <= res_d;
        end
    end

    assign eng_start   = start_q;
    assign eng_op      = op_q;
    assign eng_addr    = addr_q;
    assign eng_data    = data_q;
    assign eng_suspend = susp_q;
    assign eng_resume  = res_q;
    assign eng_abort   = ~rst_n;

endmodule

// File: rtl/fcd_checker.sv
// Module: temporal checks on the decoder's engine requests and status byte.
// Assumes it is bound to flash_cmd_decoder and sees its internal status byte.
module fcd_checker #(
    parameter int ADDR_W = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              eng_start,
    input logic [1:0]        eng_op,
    input logic [ADDR_W-1:0] eng_addr,
    input logic              eng_suspend,
    input logic              eng_resume,
    input logic [7:0]        status
);

    // R3: a start is a single-cycle pulse
    a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R4: four-byte requests are aligned
    a_r4_quad_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && eng_op == 2'd1) |-> (eng_addr[1:0] == 2'b00));

    // R7: a new protection error never comes with a start
    a_r7_prot_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> !eng_start);

    // R8: a new voltage error never comes with a start
    a_r8_vpp_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[3]) |-> !eng_start);

    // R9: a started engine reads as busy
    a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !status[7]);

    // R10: suspend shows ready and one suspend flag
    a_r10_suspend_flags: assert property (@(posedge clk) disable iff (!rst_n)
        eng_suspend |-> (status[7] && $countones({status[6], status[2]}) == 1));

    // R10: resume returns to busy
    a_r10_resume_busy: assert property (@(posedge clk) disable iff (!rst_n)
        eng_resume |-> !status[7]);

endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .eng_start(eng_start), .eng_op(eng_op),
    .eng_addr(eng_addr), .eng_suspend(eng_suspend), .eng_resume(eng_resume),
    .status(status_w)
);

// File: tb/flash_cmd_decoder_tb.sv
// Bench: vector table of write/read pairs, then directed busy, suspend,
// lock and reset tests.
module flash_cmd_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [20:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [20:0] rd_addr = '0;
    logic [7:0]  arr_rdata = 8'hA5;
    logic [7:0]  rd_data;
    logic        lock_we = 1'b0;
    logic [4:0]  lock_blk = '0;
    logic        lock_val = 1'b0;
    logic        wp_n = 1'b1, tbl_n = 1'b1, vpp_ok = 1'b1;
    logic        eng_start, eng_suspend, eng_resume, eng_abort;
    logic [1:0]  eng_op;
    logic [20:0] eng_addr;
    logic [31:0] eng_data;
    logic        eng_done = 1'b0;
    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    flash_cmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .arr_rdata(arr_rdata),
        .rd_data(rd_data), .lock_we(lock_we), .lock_blk(lock_blk),
        .lock_val(lock_val), .wp_n(wp_n), .tbl_n(tbl_n), .vpp_ok(vpp_ok),
        .eng_start(eng_start), .eng_op(eng_op), .eng_addr(eng_addr),
        .eng_data(eng_data), .eng_suspend(eng_suspend),
        .eng_resume(eng_resume), .eng_done(eng_done), .eng_abort(eng_abort)
    );

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung, got %0d cycles exp fewer", cyc);
            finish_run();
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [20:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
    endtask

    // {req, wr, wdata, waddr, wp_n, tbl_n, vpp_ok, rsel, exp_rd, exp_start}
    localparam int NV = 29;
    localparam logic [46:0] VEC [NV] = '{
        {4'd2,  1'b1, 8'hFF, 21'h000000, 3'b111, 1'b0, 8'hA5, 1'b0}, // R2 array
        {4'd2,  1'b1, 8'h90, 21'h000000, 3'b111, 1'b0, 8'h20, 1'b0}, // R2 sig 0
        {4'd2,  1'b0, 8'h00, 21'h000000, 3'b111, 1'b1, 8'h2E, 1'b0}, // R2 sig 1
        {4'd2,  1'b1, 8'h70, 21'h000000, 3'b111, 1'b0, 8'h80, 1'b0}, // R2 status
        {4'd3,  1'b1, 8'h40, 21'h000000, 3'b111, 1'b0, 8'h80, 1'b0}, // R3 setup
        {4'd3,  1'b1, 8'h5A, 21'h012345, 3'b111, 1'b0, 8'h00, 1'b1}, // R3 start
        {4'd5,  1'b1, 8'h20, 21'h000000, 3'b111, 1'b0, 8'h80, 1'b0}, // R5 setup
        {4'd6,  1'b1, 8'hD0, 21'h1F0000, 3'b101, 1'b0, 8'hA2, 1'b0}, // R6 tbl_n top
        {4'd11, 1'b1, 8'h50, 21'h000000, 3'b111, 1'b0, 8'h80, 1'b0}, // R11 clear
        {4'd5,  1'b1, 8'h20, 21'h000000, 3'b111, 1'b0, 8'h80, 1'b0}, // R5 setup
        {4'd6,  1'b1, 8'hD0, 21'h050000, 3'b011, 1'b0, 8'hA2, 1'b0}, // R6 wp_n main
        {4'd11, 1'b1, 8'h50, 21'h000000, 3'b111, 1'b0, 8'h80, 1'b0}, // R11 clear
        {4'd5,  1'b1, 8'h20, 21'h000000, 3'b011, 1'b0, 8'h80, 1'b0}, // R5 setup
        {4'd6,  1'b1, 8'hD0, 21'h1F0000, 3'b011, 1'b0, 8'h00, 1'b1}, // R6 wp_n spares top
        {4'd3,  1'b1, 8'h40, 21'h000000, 3'b101, 1'b0, 8'h80, 1'b0}, // R3 setup
        {4'd6,  1'b1, 8'hC3, 21'h0A0000, 3'b101, 1'b0, 8'h00, 1'b1}, // R6 tbl_n spares main
        {4'd8,  1'b1, 8'h40, 21'h000000, 3'b111, 1'b0, 8'h80, 1'b0}, // R8 setup
        {4'd8,  1'b1, 8'h55, 21'h000000, 3'b110, 1'b0, 8'h98, 1'b0}, // R8 vpp low
        {4'd11, 1'b1, 8'hFF, 21'h000000, 3'b111, 1'b0, 8'hA5, 1'b0}, // R11 array
        {4'd11, 1'b1, 8'h70, 21'h000000, 3'b111, 1'b0, 8'h98, 1'b0}, // R11 sticky
        {4'd11, 1'b1, 8'h50, 21'h000000, 3'b111, 1'b0, 8'h80, 1'b0}, // R11 clear
        {4'd5,  1'b1, 8'h20, 21'h000000, 3'b111, 1'b0, 8'h80, 1'b0}, // R5 setup
        {4'd5,  1'b1, 8'h33, 21'h000000, 3'b111, 1'b0, 8'hB0, 1'b0}, // R5 bad confirm
        {4'd11, 1'b1, 8'h50, 21'h000000, 3'b111, 1'b0, 8'h80, 1'b0}, // R11 clear
        {4'd5,  1'b1, 8'h80, 21'h000000, 3'b111, 1'b0, 8'h80, 1'b0}, // R5 chip setup
        {4'd5,  1'b1, 8'h10, 21'h000000, 3'b111, 1'b0, 8'h00, 1'b1}, // R5 chip start
        {4'd11, 1'b1, 8'h90, 21'h000000, 3'b111, 1'b0, 8'h20, 1'b0}, // R11 sig mode
        {4'd11, 1'b1, 8'h50, 21'h000000, 3'b111, 1'b0, 8'h20, 1'b0}, // R11 mode kept
        {4'd11, 1'b1, 8'h70, 21'h000000, 3'b111, 1'b0, 8'h80, 1'b0}  // R11 status
    };

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R12 abort in reset", 32'(eng_abort), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 array after reset", 32'(rd_data), 32'hA5);
        chk("R1 no start", 32'(eng_start), 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [46:0] v;
            string tag;
            v = VEC[i];
            wp_n = v[12]; tbl_n = v[11]; vpp_ok = v[10];
            rd_addr = {20'b0, v[9]};
            tag = $sformatf("R%0d vec %0d", v[46:43], i);
            if (v[42]) wr(v[33:13], {24'b0, v[41:34]});
            else @(negedge clk);
            chk({tag, " rd"}, 32'(rd_data), 32'(v[8:1]));
            chk({tag, " start"}, 32'(eng_start), 32'(v[0]));
            if (eng_start) done_pulse();
        end
        wp_n = 1'b1; tbl_n = 1'b1; vpp_ok = 1'b1; rd_addr = '0;

        // R3: program request fields
        wr(21'h0, 32'h10);
        wr(21'h1ABCDE, 32'hFFFFFF7E);
        chk("R3 start", 32'(eng_start), 32'd1);
        chk("R3 op", 32'(eng_op), 32'd0);
        chk("R3 addr", 32'(eng_addr), 32'h1ABCDE);
        chk("R3 data", eng_data, 32'h7E);
        done_pulse();

        // R4: four-byte program
        wr(21'h0, 32'h30);
        wr(21'h020107, 32'h44332211);
        chk("R4 start", 32'(eng_start), 32'd1);
        chk("R4 op", 32'(eng_op), 32'd1);
        chk("R4 addr", 32'(eng_addr), 32'h020104);
        chk("R4 data", eng_data, 32'h44332211);
        @(negedge clk);
        // R9: commands ignored while busy
        wr(21'h0, 32'hFF);
        chk("R9 FF ignored", 32'(rd_data), 32'h00);
        wr(21'h0, 32'h90);
        chk("R9 90 ignored", 32'(rd_data), 32'h00);
        wr(21'h0, 32'h40);
        wr(21'h0, 32'h12);
        chk("R9 no restart", 32'(eng_start), 32'd0);
        // R10: program suspend and resume
        wr(21'h0, 32'hB0);
        chk("R10 suspend pulse", 32'(eng_suspend), 32'd1);
        chk("R10 psusp status", 32'(rd_data), 32'h84);
        wr(21'h0, 32'hFF);
        chk("R10 array in suspend", 32'(rd_data), 32'hA5);
        wr(21'h0, 32'h70);
        wr(21'h0, 32'hD0);
        chk("R10 resume pulse", 32'(eng_resume), 32'd1);
        chk("R10 busy after resume", 32'(rd_data), 32'h00);
        done_pulse();
        chk("R9 ready after done", 32'(rd_data), 32'h80);

        // R10: chip erase ignores suspend
        wr(21'h0, 32'h80);
        wr(21'h0, 32'h10);
        wr(21'h0, 32'hB0);
        chk("R10 chip no suspend", 32'(eng_suspend), 32'd0);
        chk("R10 chip still busy", 32'(rd_data), 32'h00);
        done_pulse();

        // R10: erase suspend flag
        wr(21'h0, 32'h20);
        wr(21'h020000, 32'hD0);
        wr(21'h0, 32'hB0);
        chk("R10 esusp status", 32'(rd_data), 32'hC0);
        wr(21'h0, 32'hD0);
        done_pulse();
        chk("R10 flags cleared", 32'(rd_data), 32'h80);

        // R7: lock bit protects block 3
        @(negedge clk); lock_we = 1'b1; lock_blk = 5'd3; lock_val = 1'b1;
        @(negedge clk); lock_we = 1'b0;
        wr(21'h0, 32'h40);
        wr(21'h030000, 32'h11);
        chk("R7 locked no start", 32'(eng_start), 32'd0);
        chk("R7 lock status", 32'(rd_data), 32'h92);

        // R12: reset during an operation
        wr(21'h0, 32'h40);
        wr(21'h000010, 32'h22);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R12 abort", 32'(eng_abort), 32'd1);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R12 array mode", 32'(rd_data), 32'hA5);
        wr(21'h0, 32'h70);
        chk("R12 idle and clean", 32'(rd_data), 32'h80);
        wr(21'h0, 32'h40);
        wr(21'h030000, 32'h11);
        chk("R12 lock cleared", 32'(eng_start), 32'd1);
        done_pulse();

        finish_run();
    end

endmodule